// File: doc/BRIEF.md
# Conversion Frame Timing Sequencer

This block generates the control strobes for one acquisition frame of a multi-channel charge-integrating converter. A host pulse on `start_conv` begins a frame. From that moment a cycle counter runs, and every strobe edge is placed at a programmable cycle offset from the frame's first cycle. The strobes are the amplifier reset, the offset-sampling window and the signal-sampling window. A seven-entry timing table, written through a simple address/data/write-enable port, holds the offsets. Any entry that holds zero uses a parameter default.

When the frame ends, a conversion window of programmable length starts. Conversion runs in a pipeline: the value sampled in one frame is converted while the next frame integrates. A single-cycle `data_valid` pulse marks the end of each conversion. `ready` tells the host when the next `start_conv` can be taken. After reset, `ready` stays low for a fixed power-up hold-off. A `start_conv` that arrives while a frame is still sequencing is counted in a saturating overrun counter and otherwise ignored.

Timing below is written in frame cycles. Cycle t = 0 is the first clock cycle after the edge that accepts `start_conv`. The table offsets are: rst_len (addr 0), ofs_beg (1), ofs_end (2), sig_beg (3), frame_len (4), conv_len (5) and ofs_ext (6).

Top module: `conv_seq_top`

## Requirements
- R1: A `start_conv` seen at a clock edge while `ready` is high starts a frame. `ready` is low for frame cycles 0 to frame_len-1 and is high again from cycle frame_len.
- R2: After `rst_n` is released, the release passes through a two-stage synchronizer and then a hold-off of HOLDOFF cycles (default 200). `ready` first goes high after the (HOLDOFF+2)th rising edge. Any `start_conv` before that point is ignored and does not count as an overrun.
- R3: While `rst_n` is low, all strobes, `ready` and `data_valid` are low and `ovr_cnt` is zero.
- R4: `amp_rst` is high in frame cycles t < rst_len.
- R5: With `hi_gain` low, `ofs_smp` is high in frame cycles ofs_beg <= t < ofs_end.
- R6: With `hi_gain` high, the end of the offset window moves out by ofs_ext cycles, so the window covers ofs_beg <= t < ofs_end + ofs_ext.
- R7: `sig_smp` is high in frame cycles sig_beg <= t < frame_len.
- R8: `conv_en` is high for conv_len cycles, starting at frame cycle frame_len. `data_valid` is high for exactly the one cycle after the window closes.
- R9: A new frame may start while the previous conversion is still running. If a frame ends while a conversion is still running, the conversion restarts for the new sample. The abandoned conversion gives no `data_valid` unless it finishes on that same edge.
- R10: Each `start_conv` seen at an edge while a frame is sequencing is ignored and adds one to `ovr_cnt`. The counter saturates at 255.
- R11: A table write takes effect from the next cycle. A zero entry uses the default value (8, 10, 90, 100, 400, 300, 40 for addresses 0 to 6). A write to address 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_conv | input | 1 | Host frame-start request, sampled each edge |
| hi_gain | input | 1 | High-gain setting; lengthens the offset window |
| cfg_we | input | 1 | Timing table write enable |
| cfg_addr | input | 3 | Timing table entry address |
| cfg_wdata | input | 16 | Timing table write data (cycle offset) |
| amp_rst | output | 1 | Charge amplifier reset strobe |
| ofs_smp | output | 1 | Offset sampling window |
| sig_smp | output | 1 | Signal sampling window |
| conv_en | output | 1 | Conversion window |
| data_valid | output | 1 | One-cycle pulse at conversion completion |
| ready | output | 1 | Next start_conv will be accepted |
| ovr_cnt | output | 8 | Saturating count of overrun starts |

## Verification
On every cycle, the embedded properties check the following. A frame can never begin inside the hold-off. Each frame opens with its counter at zero and with the amplifier reset high. Conversion is always running on the cycle after a frame closes. A `data_valid` pulse never lasts two cycles. The overrun count never goes down.

Only the bench scenarios can show the exact cycle of each strobe edge under a given table. They also cover the gain extension, back-to-back frames overlapping with conversions, restarted conversions, saturation of the overrun count, zero-entry fallback and the ignored address.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int NUM_ENT = 7;
  localparam int ADDR_W  = 3;
  // timing table entry indices
  localparam int IX_RST  = 0;
  localparam int IX_OBEG = 1;
  localparam int IX_OEND = 2;
  localparam int IX_SBEG = 3;
  localparam int IX_FLEN = 4;
  localparam int IX_CLEN = 5;
  localparam int IX_OEXT = 6;
endpackage

// File: rtl/cts_rst_hold.sv
module cts_rst_hold #(
  parameter int HOLDOFF = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni,
  output logic hold_done
);
  localparam int HC_W = $clog2(HOLDOFF + 1);

  logic          sync1_q;
  logic          sync2_q;
  logic [HC_W-1:0] hcnt_q, hcnt_d;
  logic          done_q, done_d;

  // release synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end

  assign rst_ni = sync2_q;

  always_comb begin
    hcnt_d = hcnt_q;
    done_d = done_q;
    if (!done_q) begin
      hcnt_d = hcnt_q + 1'b1;
      done_d = (hcnt_q == HC_W'(HOLDOFF - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      hcnt_q <= hcnt_d;
      done_q <= done_d;
    end
  end

  assign hold_done = done_q;
endmodule

// File: rtl/cts_table.sv
module cts_table
  import cts_pkg::*;
#(
  parameter int TW = 16,
  parameter logic [NUM_ENT-1:0][TW-1:0] DEFS = '0
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [TW-1:0]                 wdata,
  output logic [NUM_ENT-1:0][TW-1:0]    tab_eff
);
  logic [NUM_ENT-1:0][TW-1:0] ent_q;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic wr_en;
    assign wr_en = we && (addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[i] <= '0;
      end else if (wr_en) begin
        ent_q[i] <= wdata;
      end
    end

    // zero selects the built-in default
    assign tab_eff[i] = (ent_q[i] == '0) ? DEFS[i] : ent_q[i];
  end
endmodule

// File: rtl/cts_frame.sv
module cts_frame
  import cts_pkg::*;
#(
  parameter int TW    = 16,
  parameter int OVR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       hold_done,
  input  logic                       start_conv,
  input  logic                       hi_gain,
  input  logic [NUM_ENT-1:0][TW-1:0] tab_eff,
  output logic                       busy,
  output logic                       frame_end,
  output logic                       amp_rst,
  output logic                       ofs_smp,
  output logic                       sig_smp,
  output logic [OVR_W-1:0]           ovr_cnt
);
  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  logic            busy_q, busy_d;
  logic [TW-1:0]   cnt_q, cnt_d;
  logic [OVR_W-1:0] ovr_q, ovr_d;
  logic            accept, fin, ovr_hit;
  logic            cnt_en;
  logic [TW:0]     oend_x;

  assign accept  = start_conv && !busy_q && hold_done;
  assign fin     = busy_q && (cnt_q == (tab_eff[IX_FLEN] - {{(TW-1){1'b0}}, 1'b1}));
  assign ovr_hit = start_conv && busy_q && (ovr_q != OVR_MAX);
  assign cnt_en  = accept || busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    ovr_d  = ovr_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (fin) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (ovr_hit) ovr_d = ovr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= '0;
    end else if (ovr_hit) begin
      ovr_q <= ovr_d;
    end
  end

  // strobe decode from the frame counter
  assign oend_x  = {1'b0, tab_eff[IX_OEND]} + (hi_gain ? {1'b0, tab_eff[IX_OEXT]} : '0);
  assign amp_rst = busy_q && (cnt_q < tab_eff[IX_RST]);
  assign ofs_smp = busy_q && (cnt_q >= tab_eff[IX_OBEG]) && ({1'b0, cnt_q} < oend_x);
  assign sig_smp = busy_q && (cnt_q >= tab_eff[IX_SBEG]);

  assign busy      = busy_q;
  assign frame_end = fin;
  assign ovr_cnt   = ovr_q;

  p_frame_opens_at_zero_r1 : assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy_q) |-> (cnt_q == '0));
  p_no_frame_in_holdoff_r2 : assert property (@(posedge clk) disable iff (!rst_ni)
    !hold_done |-> !busy_q);
  p_ovr_monotonic_r10 : assert property (@(posedge clk) disable iff (!rst_ni)
    ovr_q >= $past(ovr_q));
endmodule

// File: rtl/cts_conv.sv
module cts_conv #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          launch,
  input  logic [TW-1:0] conv_len,
  output logic          conv_en,
  output logic          data_valid
);
  logic          act_q, act_d;
  logic [TW-1:0] ccnt_q, ccnt_d;
  logic          dv_q;
  logic          done;
  logic          run_en;

  assign done   = act_q && (ccnt_q == (conv_len - {{(TW-1){1'b0}}, 1'b1}));
  assign run_en = launch || act_q;

  always_comb begin
    act_d  = act_q;
    ccnt_d = ccnt_q;
    if (launch) begin
      act_d  = 1'b1;
      ccnt_d = '0;
    end else if (done) begin
      act_d = 1'b0;
    end else if (act_q) begin
      ccnt_d = ccnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ccnt_q <= '0;
    end else if (run_en) begin
      act_q  <= act_d;
      ccnt_q <= ccnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) dv_q <= 1'b0;
    else         dv_q <= done;
  end

  assign conv_en    = act_q;
  assign data_valid = dv_q;

  p_dv_single_cycle_r8 : assert property (@(posedge clk) disable iff (!rst_ni)
    dv_q |=> !dv_q);
endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top
  import cts_pkg::*;
#(
  parameter int TW      = 16,
  parameter int HOLDOFF = 200,
  parameter int OVR_W   = 8,
  parameter int D_RST   = 8,
  parameter int D_OBEG  = 10,
  parameter int D_OEND  = 90,
  parameter int D_SBEG  = 100,
  parameter int D_FLEN  = 400,
  parameter int D_CLEN  = 300,
  parameter int D_OEXT  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_conv,
  input  logic              hi_gain,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic              amp_rst,
  output logic              ofs_smp,
  output logic              sig_smp,
  output logic              conv_en,
  output logic              data_valid,
  output logic              ready,
  output logic [7:0]        ovr_cnt
);
  localparam logic [NUM_ENT-1:0][TW-1:0] DEFS = '{
    TW'(D_OEXT), TW'(D_CLEN), TW'(D_FLEN), TW'(D_SBEG),
    TW'(D_OEND), TW'(D_OBEG), TW'(D_RST)};

  logic                       rst_ni;
  logic                       hold_done;
  logic [NUM_ENT-1:0][TW-1:0] tab_eff;
  logic                       busy;
  logic                       frame_end;

  cts_rst_hold #(.HOLDOFF(HOLDOFF)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_ni    (rst_ni),
    .hold_done (hold_done)
  );

  cts_table #(.TW(TW), .DEFS(DEFS)) u_table (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata[TW-1:0]),
    .tab_eff (tab_eff)
  );

  cts_frame #(.TW(TW), .OVR_W(OVR_W)) u_frame (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .hold_done  (hold_done),
    .start_conv (start_conv),
    .hi_gain    (hi_gain),
    .tab_eff    (tab_eff),
    .busy       (busy),
    .frame_end  (frame_end),
    .amp_rst    (amp_rst),
    .ofs_smp    (ofs_smp),
    .sig_smp    (sig_smp),
    .ovr_cnt    (ovr_cnt)
  );

  cts_conv #(.TW(TW)) u_conv (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .launch     (frame_end),
    .conv_len   (tab_eff[IX_CLEN]),
    .conv_en    (conv_en),
    .data_valid (data_valid)
  );

  assign ready = hold_done && !busy;

  p_amp_reset_leads_r4 : assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> amp_rst);
  p_conv_follows_frame_r8 : assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy) |-> conv_en);
endmodule

// File: tb/conv_seq_top_tb.sv
module conv_seq_top_tb;
  localparam int HOLD = 200;
  int DEF [7] = '{8, 10, 90, 100, 400, 300, 40};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_conv, hi_gain, cfg_we;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        amp_rst, ofs_smp, sig_smp, conv_en, data_valid, ready;
  logic [7:0]  ovr_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit chk_on  = 0;
  string conv_tag = "R8";

  always #2.5 clk = ~clk;

  conv_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .start_conv(start_conv), .hi_gain(hi_gain),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .amp_rst(amp_rst), .ofs_smp(ofs_smp), .sig_smp(sig_smp), .conv_en(conv_en),
    .data_valid(data_valid), .ready(ready), .ovr_cnt(ovr_cnt));

  // bench-side reference state, built from the requirements
  int tr [7];
  int m_edges, m_age, m_cage, m_ovr;
  bit m_busy, m_cbusy, m_dv, m_acc;

  function automatic int eff(int i);
    return (tr[i] == 0) ? DEF[i] : tr[i];
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_edges <= 0; m_age <= 0; m_cage <= 0; m_ovr <= 0;
      m_busy <= 0; m_cbusy <= 0; m_dv <= 0;
      for (int i = 0; i < 7; i++) tr[i] <= 0;
    end else begin
      if (m_edges < 1000000) m_edges <= m_edges + 1;
      if (cfg_we && cfg_addr < 3'd7) tr[cfg_addr] <= int'(cfg_wdata);
      m_acc = start_conv && !m_busy && (m_edges >= HOLD + 2);
      m_dv <= 0;
      if (m_cbusy) begin
        if (m_cage == eff(5) - 1) begin m_cbusy <= 0; m_dv <= 1; end
        else m_cage <= m_cage + 1;
      end
      if (m_acc) begin
        m_busy <= 1; m_age <= 0;
      end else if (m_busy) begin
        if (m_age == eff(4) - 1) begin m_busy <= 0; m_cbusy <= 1; m_cage <= 0; end
        else m_age <= m_age + 1;
      end
      if (start_conv && m_busy && m_ovr < 255) m_ovr <= m_ovr + 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      int oe;
      oe = eff(2) + (hi_gain ? eff(6) : 0);
      if (!rst_n) begin
        chk("R3", {amp_rst, ofs_smp, sig_smp, conv_en, data_valid, ready}, 0);
        chk("R3", ovr_cnt, 0);
      end else begin
        chk((m_edges < HOLD + 3) ? "R2" : "R1", ready, !m_busy && (m_edges >= HOLD + 2));
        chk("R4", amp_rst, m_busy && m_age < eff(0));
        chk(hi_gain ? "R6" : "R5", ofs_smp, m_busy && m_age >= eff(1) && m_age < oe);
        chk("R7", sig_smp, m_busy && m_age >= eff(3));
        chk(conv_tag, conv_en, m_cbusy);
        chk(conv_tag, data_valid, m_dv);
        chk("R10", ovr_cnt, m_ovr);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(negedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic wait_idle();
    while (m_busy || m_cbusy) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk); #1; start_conv = 1;
    @(negedge clk); #1; start_conv = 0;
  endtask

  task automatic measure_frame(output int len);
    wait_idle();
    pulse();
    len = 1;
    @(negedge clk);
    while (!ready) begin len++; @(negedge clk); end
  endtask

  task automatic rand_run(int ncyc, int rate);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk); #1;
      start_conv = ($urandom % rate) == 0;
      if (($urandom % 16) == 0) hi_gain = $urandom % 2;
    end
    @(negedge clk); #1; start_conv = 0;
  endtask

  initial begin
    int len;
    void'($urandom(32'h5EED_0F15));
    rst_n = 0; start_conv = 0; hi_gain = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    chk_on = 1;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    // R2: start during hold-off is ignored
    repeat (50) @(negedge clk);
    #1 start_conv = 1;
    @(negedge clk); #1 start_conv = 0;
    while (!ready) @(negedge clk);
    chk("R2", m_edges, HOLD + 2);
    // defaults, both gain settings
    pulse(); wait_idle();
    hi_gain = 1; pulse(); wait_idle(); hi_gain = 0;
    // random tables with random start streams (R9 restarts when conv_len > frame_len)
    for (int k = 0; k < 20; k++) begin
      int r, ob, oe, ex, sb, fl, cl;
      r = 1 + $urandom % 6; ob = r + $urandom % 4; oe = ob + 1 + $urandom % 20;
      ex = 1 + $urandom % 10; sb = oe + ex + $urandom % 5; fl = sb + 1 + $urandom % 30;
      cl = 1 + $urandom % (fl + 10);
      conv_tag = (cl > fl) ? "R9" : "R8";
      wait_idle();
      wr(0, r); wr(1, ob); wr(2, oe); wr(6, ex); wr(3, sb); wr(4, fl); wr(5, cl);
      rand_run(3 * fl, 1 + $urandom % 10);
    end
    // R9 directed: conversion longer than frame, back-to-back frames
    wait_idle(); conv_tag = "R9";
    wr(4, 20); wr(3, 15); wr(2, 12); wr(1, 4); wr(0, 2); wr(6, 1); wr(5, 30);
    @(negedge clk); #1 start_conv = 1;
    repeat (120) @(negedge clk);
    #1 start_conv = 0;
    wait_idle(); conv_tag = "R8";
    // R11: address 7 ignored, frame keeps programmed length
    wr(7, 5);
    measure_frame(len);
    chk("R11", len, 20);
    // R11: zero restores default frame length
    wr(4, 0); wr(3, 0);
    measure_frame(len);
    chk("R11", len, DEF[4]);
    // R10: saturation with start held across default frames
    wait_idle();
    @(negedge clk); #1 start_conv = 1;
    repeat (700) @(negedge clk);
    #1 start_conv = 0;
    wait_idle();
    chk("R10", ovr_cnt, 255);
    // R3: asynchronous reset clears everything
    @(negedge clk); #1 start_conv = 1;
    repeat (3) @(negedge clk);
    #1 rst_n = 0;
    #1 chk("R3", {amp_rst, ofs_smp, sig_smp, conv_en, data_valid, ready}, 0);
    chk("R3", ovr_cnt, 0);
    start_conv = 0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule